// File: doc/BRIEF.md
# Signed Charge Counter with Fractional Carry

This block keeps a running signed count of charge that has moved into or out of a battery. Each time a current sample is published (a signed value together with a one-cycle valid strobe), the sample is scaled by a fixed gain. The scaled value is added to a wide fixed-point total. The upper part of that total is the 16-bit two's-complement charge count. The lower part is a fractional residue that holds charge too small to show up in the count. Charging samples (positive) raise the count and discharging samples (negative) lower it. With the default widths, one count step is 16384 current-LSB updates. For a 0.625 mA current step and an update roughly every 88 ms, that is about 0.25 mAh per count, and the full range is near ±8.2 Ah.

A host sees the count as two bytes on a small byte-wide port. The high byte is at address 0 and the low byte at address 1. The host may overwrite either byte at any time. A host write also discards the fractional residue. The count is also available as a full word on a separate output.

Top module: `coulomb_acc`

## Requirements
- R1: After reset the charge count is 0 and the fractional residue is 0.
- R2: A valid update with a positive current adds current × GAIN to the fixed-point total. The count is the total divided by 2^FRAC_W, rounded down, so it never falls.
- R3: A valid update with a negative current subtracts from the total, borrowing from the count when the residue runs out. Starting from a zero residue, a current of -1 makes the count drop by one.
- R4: The total never wraps above its maximum. Once the count is 0x7FFF with a full residue, further positive updates leave it at 0x7FFF.
- R5: The total never wraps below its minimum. Once the count is 0x8000 with a zero residue, further negative updates leave it at 0x8000.
- R6: A host write to address 0 replaces count bits 15:8, and a write to address 1 replaces bits 7:0. The other byte is kept. The new value is visible on the cycle after the write.
- R7: A host write clears the fractional residue to zero.
- R8: When a host write and a valid update arrive in the same cycle, the write takes effect and the update is dropped entirely.
- R9: host_rdata shows the count's high byte when host_addr is 0 and its low byte when host_addr is 1, in the same cycle.
- R10: With neither a valid update nor a host write, the count and residue hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_vld | input | 1 | One-cycle strobe: a new current sample is present |
| cur_val | input | CUR_W (13) | Signed current sample; positive means charging |
| host_we | input | 1 | Host byte write enable |
| host_addr | input | ADDR_W (1) | Byte address: 0 is the high byte, 1 is the low byte |
| host_wdata | input | 8 | Byte to write |
| host_rdata | output | 8 | Byte of the count selected by host_addr |
| acc_value | output | ACC_W (16) | Full signed charge count |

## Verification
The count takes one register stage. An update or a write applied before a rising edge shows on acc_value just after that edge. The read byte on host_rdata is combinational from the registered count and the current address. The bench therefore drives every input on the falling edge and checks host_rdata a nanosecond later, against the model's value from before that operation. It then checks acc_value a nanosecond after the next rising edge, against the model's value after the operation. The model keeps the full fixed-point total as a 64-bit integer, so carries, borrows and saturation fall out of plain integer arithmetic and clamping.

// File: rtl/coulomb_pkg.sv
package coulomb_pkg;

  localparam int BYTE_W = 8;

  // Host address of byte lane i (lane 0 = least significant); high byte sits lowest.
  function automatic int lane_addr(input int lane, input int nbytes);
    return nbytes - 1 - lane;
  endfunction

endpackage

// File: rtl/cc_step_scale.sv
module cc_step_scale #(
  parameter int CUR_W = 13,
  parameter int TOT_W = 30,
  parameter int GAIN  = 1
) (
  input  logic signed [CUR_W-1:0] cur,
  output logic signed [TOT_W-1:0] step
);

  function automatic logic signed [TOT_W-1:0] scale(input logic signed [CUR_W-1:0] c);
    logic signed [TOT_W-1:0] wide;
    wide = TOT_W'(c);
    return wide * $signed(TOT_W'(GAIN));
  endfunction

  always_comb step = scale(cur);

endmodule

// File: rtl/cc_sat_adder.sv
module cc_sat_adder #(
  parameter int TOT_W = 30
) (
  input  logic signed [TOT_W-1:0] total,
  input  logic signed [TOT_W-1:0] step,
  output logic signed [TOT_W-1:0] next,
  output logic                    sat_hi,
  output logic                    sat_lo
);

  localparam logic signed [TOT_W-1:0] T_MAX = {1'b0, {(TOT_W-1){1'b1}}};
  localparam logic signed [TOT_W-1:0] T_MIN = {1'b1, {(TOT_W-1){1'b0}}};

  function automatic logic signed [TOT_W:0] wide_sum(input logic signed [TOT_W-1:0] a,
                                                     input logic signed [TOT_W-1:0] b);
    return {a[TOT_W-1], a} + {b[TOT_W-1], b};
  endfunction

  logic signed [TOT_W:0] sum;

  always_comb begin
    sum    = wide_sum(total, step);
    sat_hi = !sum[TOT_W] &&  sum[TOT_W-1];
    sat_lo =  sum[TOT_W] && !sum[TOT_W-1];
    if (sat_hi)      next = T_MAX;
    else if (sat_lo) next = T_MIN;
    else             next = sum[TOT_W-1:0];
  end

endmodule

// File: rtl/cc_host_port.sv
module cc_host_port
  import coulomb_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int NBYTES = ACC_W / BYTE_W,
  parameter int ADDR_W = 1
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [ACC_W-1:0]  merged,
  output logic [BYTE_W-1:0] rdata
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    localparam logic [ADDR_W-1:0] LA = ADDR_W'(lane_addr(g, NBYTES));
    assign merged[g*BYTE_W +: BYTE_W] = (we && addr == LA) ? wdata : acc[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (addr == ADDR_W'(lane_addr(i, NBYTES))) rdata = acc[i*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/coulomb_acc.sv
module coulomb_acc
  import coulomb_pkg::*;
#(
  parameter int CUR_W  = 13,
  parameter int ACC_W  = 16,
  parameter int FRAC_W = 14,
  parameter int GAIN   = 1,
  parameter int NBYTES = ACC_W / 8,
  parameter int ADDR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cur_vld,
  input  logic signed [CUR_W-1:0] cur_val,
  input  logic                    host_we,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [7:0]              host_wdata,
  output logic [7:0]              host_rdata,
  output logic [ACC_W-1:0]        acc_value
);

  localparam int TOT_W = ACC_W + FRAC_W;

  logic signed [TOT_W-1:0] total_q, total_d, step, sum_sat;
  logic [ACC_W-1:0]        merged;
  logic                    sat_hi, sat_lo;

  // Named internal events.
  logic upd_take, host_take, resid_clr;
  assign host_take = host_we;
  assign upd_take  = cur_vld && !host_we;
  assign resid_clr = host_take;

  cc_step_scale #(.CUR_W(CUR_W), .TOT_W(TOT_W), .GAIN(GAIN)) u_scale (
    .cur  (cur_val),
    .step (step)
  );

  cc_sat_adder #(.TOT_W(TOT_W)) u_add (
    .total  (total_q),
    .step   (step),
    .next   (sum_sat),
    .sat_hi (sat_hi),
    .sat_lo (sat_lo)
  );

  cc_host_port #(.ACC_W(ACC_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_host (
    .acc    (acc_value),
    .we     (host_we),
    .addr   (host_addr),
    .wdata  (host_wdata),
    .merged (merged),
    .rdata  (host_rdata)
  );

  always_comb begin
    total_d = total_q;
    if (host_take)     total_d = {merged, {FRAC_W{1'b0}}};
    else if (upd_take) total_d = sum_sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) total_q <= '0;
    else        total_q <= total_d;
  end

  assign acc_value = total_q[TOT_W-1:FRAC_W];

endmodule

// File: rtl/coulomb_acc_chk.sv
module coulomb_acc_chk #(
  parameter int CUR_W  = 13,
  parameter int ACC_W  = 16,
  parameter int NBYTES = 2,
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cur_vld,
  input logic [CUR_W-1:0]  cur_val,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic [ACC_W-1:0]  acc_value
);

  localparam logic [ACC_W-1:0]  A_MAX  = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  A_MIN  = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] HI_ADR = '0;
  localparam logic [ADDR_W-1:0] LO_ADR = ADDR_W'(NBYTES - 1);

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_vld && !host_we) |=> $stable(acc_value));

  a_r2_charge_up: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vld && !host_we && $signed(cur_val) > 0)
      |=> $signed(acc_value) >= $signed($past(acc_value)));

  a_r3_discharge_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vld && !host_we && $signed(cur_val) < 0)
      |=> $signed(acc_value) <= $signed($past(acc_value)));

  a_r4_no_wrap_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vld && !host_we && !cur_val[CUR_W-1] && acc_value == A_MAX) |=> acc_value == A_MAX);

  a_r5_no_wrap_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vld && !host_we && cur_val[CUR_W-1] && acc_value == A_MIN) |=> acc_value == A_MIN);

  a_r6_high_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == HI_ADR) |=> acc_value[ACC_W-1 -: 8] == $past(host_wdata));

  a_r6_low_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == LO_ADR) |=> acc_value[7:0] == $past(host_wdata));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && cur_vld && host_addr == LO_ADR)
      |=> acc_value[ACC_W-1:8] == $past(acc_value[ACC_W-1:8]));

endmodule

bind coulomb_acc coulomb_acc_chk #(
  .CUR_W(CUR_W), .ACC_W(ACC_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cur_vld    (cur_vld),
  .cur_val    (cur_val),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .acc_value  (acc_value)
);

// File: tb/tb_coulomb_acc.sv
module tb_coulomb_acc;

  localparam int  CUR_W = 13;
  localparam int  FRAC  = 14;
  localparam int  GAIN  = 1;
  localparam longint TMAX = (64'sd1 <<< 29) - 1;
  localparam longint TMIN = -(64'sd1 <<< 29);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cur_vld = 1'b0;
  logic signed [CUR_W-1:0] cur_val = '0;
  logic host_we = 1'b0;
  logic [0:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [15:0] acc_value;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  longint model = 0;

  always #2 clk = ~clk;

  coulomb_acc dut (
    .clk(clk), .rst_n(rst_n), .cur_vld(cur_vld), .cur_val(cur_val),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .acc_value(acc_value)
  );

  function automatic longint after_upd(longint t, int c);
    longint s = t + longint'(c) * GAIN;
    if (s > TMAX) s = TMAX;
    if (s < TMIN) s = TMIN;
    return s;
  endfunction

  function automatic logic [15:0] count_of(longint t);
    longint q = t >>> FRAC;
    return q[15:0];
  endfunction

  function automatic longint after_wr(longint t, bit a, logic [7:0] d);
    logic [15:0] c = count_of(t);
    if (a == 1'b0) c[15:8] = d; else c[7:0] = d;
    return longint'($signed(c)) <<< FRAC;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic op(input bit vld, input int c, input bit we, input bit a,
                    input logic [7:0] d, input string tag);
    logic [7:0] exp_rd;
    logic [15:0] cnt;
    @(negedge clk);
    cur_vld = vld; cur_val = CUR_W'(c); host_we = we; host_addr = a; host_wdata = d;
    #1;
    cnt = count_of(model);
    exp_rd = a ? cnt[7:0] : cnt[15:8];
    chk(host_rdata == exp_rd, "R9 read byte", host_rdata, exp_rd);
    if (we)       model = after_wr(model, a, d);
    else if (vld) model = after_upd(model, c);
    @(posedge clk);
    #1;
    chk(acc_value == count_of(model), tag, acc_value, count_of(model));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(acc_value == 16'h0000, "R1 reset count", acc_value, 0);
    rst_n = 1'b1;
    // R7: build a residue, overwrite, then -1 must borrow from a zero residue.
    repeat (3) op(1, 4095, 0, 0, 8'h00, "R2 residue build");
    op(0, 0, 1, 0, 8'h00, "R6 write high");
    op(0, 0, 1, 1, 8'h00, "R7 write clears residue");
    op(1, -1, 0, 0, 8'h00, "R7 R3 borrow after clear");
    chk(acc_value == 16'hFFFF, "R3 floor to -1", acc_value, 16'hFFFF);
    // R2: carry after 16384 units.
    op(0, 0, 1, 0, 8'h00, "R6 write high");
    op(0, 0, 1, 1, 8'h00, "R6 write low");
    repeat (4) op(1, 4095, 0, 0, 8'h00, "R2 below carry");
    op(1, 4095, 0, 0, 8'h00, "R2 carry");
    chk(acc_value == 16'h0001, "R2 one step", acc_value, 1);
    // R6 / R9 bytes.
    op(0, 0, 1, 0, 8'h12, "R6 high");
    op(0, 0, 1, 1, 8'h34, "R6 low");
    chk(acc_value == 16'h1234, "R6 merged", acc_value, 16'h1234);
    op(0, 0, 0, 0, 8'h00, "R10 idle read high");
    op(0, 0, 0, 1, 8'h00, "R10 idle read low");
    // R8: coincident write wins.
    op(1, 4095, 1, 1, 8'h56, "R8 write wins");
    op(1, -4096, 1, 0, 8'h9A, "R8 write wins");
    chk(acc_value == 16'h9A56, "R8 update dropped", acc_value, 16'h9A56);
    // R4 high saturation.
    op(0, 0, 1, 0, 8'h7F, "R6 high");
    op(0, 0, 1, 1, 8'hFF, "R6 low");
    repeat (10) op(1, 4095, 0, 0, 8'h00, "R4 saturate high");
    chk(acc_value == 16'h7FFF, "R4 pinned", acc_value, 16'h7FFF);
    op(1, -1, 0, 0, 8'h00, "R4 step back from max");
    // R5 low saturation.
    op(0, 0, 1, 0, 8'h80, "R6 high");
    op(0, 0, 1, 1, 8'h00, "R6 low");
    repeat (10) op(1, -4096, 0, 0, 8'h00, "R5 saturate low");
    chk(acc_value == 16'h8000, "R5 pinned", acc_value, 16'h8000);
    op(1, 1, 0, 0, 8'h00, "R5 step up from min");
    // Random mix.
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom_range(0, 1) == 1);
      bit w = ($urandom_range(0, 7) == 0);
      bit a = ($urandom_range(0, 1) == 1);
      int c = int'($urandom_range(0, 8191)) - 4096;
      logic [7:0] d = 8'($urandom());
      if (w)      op(v, c, 1, a, d, v ? "R8 random write+update" : "R6 R7 random write");
      else if (!v) op(0, c, 0, a, d, "R10 random idle");
      else if (c < 0) op(1, c, 0, a, d, "R3 R5 random discharge");
      else        op(1, c, 0, a, d, "R2 R4 random charge");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule